// File: doc/BRIEF.md
# Operand Forwarding and Load-Use Interlock Unit

This unit sits beside the Decode stage of a five-stage, fully forwarded, in-order integer pipeline. Each cycle it receives the operation class and the three register-number fields of the instruction waiting in Decode. From these it works out which register that instruction will write, whether it writes at all, and which of its two source operands it actually reads. It keeps a shadow record of the destination and write enable of the instructions that have moved on to Execute, Memory and Writeback. It compares the Decode sources against that record and produces two outputs. The first is a select code for each of the two Decode operand multiplexers, which pick between the register file and the Execute, Memory or Writeback results. The second is a stall request for when no forwarding path can supply a value in time.

When the unit stalls, the surrounding pipeline keeps the same instruction in Decode. The unit puts an empty slot into its own Execute record, so the held instruction finds its producer one stage further on in the next cycle. The register file, the ALU, the forwarding multiplexers and branch resolution are not part of this block.

Top module: `pipe_hazard_unit`

## Requirements
- R1: After reset all three shadow stages are empty, so no Decode instruction is stalled or forwarded until instructions have entered.
- R2: Destination decode uses the class codes ALU=1, ALUI=2, LW=3, SW=4, BZ=5, J=6, JAL=7, JR=8, JALR=9 and NOP=0. ALU writes rd, and ALUI and LW write rt, each only when that field is nonzero. JAL and JALR always write register 31. Every other class writes nothing.
- R3: Operand A (the rs field) is read by ALU, ALUI, LW, SW, BZ, JR and JALR. When the class is J, JAL, NOP or an unused code, selA is 0.
- R4: Operand B (the rt field) is read only by ALU and SW. For every other class, selB is 0.
- R5: The select codes are 0 = register file, 1 = Execute, 2 = Memory and 3 = Writeback. A read source that matches the Execute destination of an ALU or ALUI instruction gets code 1.
- R6: stallD is 1 when a read source matches the destination of an LW, JAL or JALR in Execute. While stalled, both select codes are 0.
- R7: If several stages write the matched register, the youngest one supplies it: Execute before Memory before Writeback.
- R8: Any writing instruction in Memory or Writeback, loads included, can be forwarded, with code 2 or 3.
- R9: A stall places an empty slot in Execute. The held instruction, presented again, gets code 2 from its producer in Memory and does not stall twice in a row.
- R10: A source field of register 0 always gets code 0, whatever the in-flight destinations are.
- R11: Instructions that write nothing (SW, BZ, J, JR, NOP) are never picked as a forwarding source.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the shadow stages advance on the rising edge |
| rstN | input | 1 | Asynchronous active-low reset, empties the shadow stages |
| opClassD | input | 4 | Operation class of the Decode instruction (codes in R2) |
| rsD | input | REG_ADDR_W | rs field of the Decode instruction |
| rtD | input | REG_ADDR_W | rt field of the Decode instruction |
| rdD | input | REG_ADDR_W | rd field of the Decode instruction |
| stallD | output | 1 | Hold Decode and insert an empty slot into Execute |
| selA | output | 2 | Operand A source select (codes in R5) |
| selB | output | 2 | Operand B source select (codes in R5) |

## Verification
The bench builds the unit with the default 5-bit register number and 31 as the link register. This makes every register reachable and lets the fixed link destination of JAL and JALR collide with an ordinary rs or rt of 31. One vector stream moves a chain of dependent instructions through the shadow stages, so that every select code, the youngest-stage priority and all three kinds of Execute interlock occur, each followed by the replayed instruction that picks up its value from Memory. Directed cases then cover the empty state after reset, including a reset applied while writers are in flight.

// File: rtl/hazard_pkg.sv
package hazard_pkg;

  // Number of downstream stages tracked: Execute, Memory, Writeback
  localparam int NUM_FWD_STAGES = 3;

  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,
    OP_ALU  = 4'd1,
    OP_ALUI = 4'd2,
    OP_LW   = 4'd3,
    OP_SW   = 4'd4,
    OP_BZ   = 4'd5,
    OP_J    = 4'd6,
    OP_JAL  = 4'd7,
    OP_JR   = 4'd8,
    OP_JALR = 4'd9
  } opClass_e;

  typedef enum logic [1:0] {
    SRC_RF  = 2'd0,
    SRC_EX  = 2'd1,
    SRC_MEM = 2'd2,
    SRC_WB  = 2'd3
  } opSrc_e;

  // Strobes from the control half to the tracking half
  typedef struct packed {
    logic stall;
    logic bubble;
  } hazCtl_t;

  function automatic logic readsRs(opClass_e c);
    case (c)
      OP_ALU, OP_ALUI, OP_LW, OP_SW, OP_BZ, OP_JR, OP_JALR: readsRs = 1'b1;
      default:                                              readsRs = 1'b0;
    endcase
  endfunction

  function automatic logic readsRt(opClass_e c);
    case (c)
      OP_ALU, OP_SW: readsRt = 1'b1;
      default:       readsRt = 1'b0;
    endcase
  endfunction

  // A result that is ready at the end of Execute
  function automatic logic exForwardable(opClass_e c);
    case (c)
      OP_ALU, OP_ALUI: exForwardable = 1'b1;
      default:         exForwardable = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/hazard_track.sv
module hazard_track
  import hazard_pkg::*;
#(
  parameter int REG_ADDR_W = 5,
  parameter int LINK_REG   = 31
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  opClass_e              clsD,
  input  logic [REG_ADDR_W-1:0] rtD,
  input  logic [REG_ADDR_W-1:0] rdD,
  input  hazCtl_t               ctl,
  output opClass_e              slotCls  [NUM_FWD_STAGES],
  output logic [REG_ADDR_W-1:0] slotDest [NUM_FWD_STAGES],
  output logic                  slotWr   [NUM_FWD_STAGES]
);

  localparam logic [REG_ADDR_W-1:0] LINK_ADDR = REG_ADDR_W'(LINK_REG);
  localparam logic [REG_ADDR_W-1:0] ZERO_ADDR = '0;

  logic [REG_ADDR_W-1:0] destD;
  logic                  wrD;

  // Destination and write enable of the Decode instruction
  always_comb begin
    destD = ZERO_ADDR;
    wrD   = 1'b0;
    case (clsD)
      OP_ALU: begin
        destD = rdD;
        wrD   = (rdD != ZERO_ADDR);
      end
      OP_ALUI, OP_LW: begin
        destD = rtD;
        wrD   = (rtD != ZERO_ADDR);
      end
      OP_JAL, OP_JALR: begin
        destD = LINK_ADDR;
        wrD   = 1'b1;
      end
      default: begin
        destD = ZERO_ADDR;
        wrD   = 1'b0;
      end
    endcase
  end

  // Shadow pipeline: slot 0 = Execute, 1 = Memory, 2 = Writeback
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_FWD_STAGES; s++) begin
        slotCls[s]  <= OP_NOP;
        slotDest[s] <= ZERO_ADDR;
        slotWr[s]   <= 1'b0;
      end
    end else begin
      for (int s = NUM_FWD_STAGES - 1; s > 0; s--) begin
        slotCls[s]  <= slotCls[s-1];
        slotDest[s] <= slotDest[s-1];
        slotWr[s]   <= slotWr[s-1];
      end
      if (ctl.bubble) begin
        slotCls[0]  <= OP_NOP;
        slotDest[0] <= ZERO_ADDR;
        slotWr[0]   <= 1'b0;
      end else begin
        slotCls[0]  <= clsD;
        slotDest[0] <= destD;
        slotWr[0]   <= wrD;
      end
    end
  end

endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
  import hazard_pkg::*;
#(
  parameter int REG_ADDR_W = 5
) (
  input  opClass_e              clsD,
  input  logic [REG_ADDR_W-1:0] rsD,
  input  logic [REG_ADDR_W-1:0] rtD,
  input  opClass_e              slotCls  [NUM_FWD_STAGES],
  input  logic [REG_ADDR_W-1:0] slotDest [NUM_FWD_STAGES],
  input  logic                  slotWr   [NUM_FWD_STAGES],
  output hazCtl_t               ctl,
  output opSrc_e                selA,
  output opSrc_e                selB
);

  localparam int NUM_PORTS = 2;
  localparam logic [REG_ADDR_W-1:0] ZERO_ADDR = '0;

  logic stallAny;

  generate
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      logic [REG_ADDR_W-1:0] srcIdx;
      logic                  srcEn;
      opSrc_e                pick;
      logic                  haz;

      if (p == 0) begin : g_rs
        assign srcIdx = rsD;
        assign srcEn  = readsRs(clsD);
      end else begin : g_rt
        assign srcIdx = rtD;
        assign srcEn  = readsRt(clsD);
      end

      // Oldest first, so a younger match overrides an older one
      always_comb begin
        pick = SRC_RF;
        haz  = 1'b0;
        for (int s = NUM_FWD_STAGES - 1; s >= 0; s--) begin
          if (srcEn && (srcIdx != ZERO_ADDR) && slotWr[s] && (slotDest[s] == srcIdx)) begin
            if ((s == 0) && !exForwardable(slotCls[0])) begin
              pick = SRC_RF;
              haz  = 1'b1;
            end else begin
              pick = opSrc_e'(2'(s + 1));
              haz  = 1'b0;
            end
          end
        end
      end
    end
  endgenerate

  assign stallAny   = g_port[0].haz | g_port[1].haz;
  assign ctl.stall  = stallAny;
  assign ctl.bubble = stallAny;
  assign selA       = stallAny ? SRC_RF : g_port[0].pick;
  assign selB       = stallAny ? SRC_RF : g_port[1].pick;

endmodule

// File: rtl/pipe_hazard_unit.sv
module pipe_hazard_unit
  import hazard_pkg::*;
#(
  parameter int REG_ADDR_W = 5,
  parameter int LINK_REG   = 31
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [3:0]            opClassD,
  input  logic [REG_ADDR_W-1:0] rsD,
  input  logic [REG_ADDR_W-1:0] rtD,
  input  logic [REG_ADDR_W-1:0] rdD,
  output logic                  stallD,
  output logic [1:0]            selA,
  output logic [1:0]            selB
);

  opClass_e              clsD;
  hazCtl_t               ctl;
  opClass_e              slotCls  [NUM_FWD_STAGES];
  logic [REG_ADDR_W-1:0] slotDest [NUM_FWD_STAGES];
  logic                  slotWr   [NUM_FWD_STAGES];
  opSrc_e                selAInt;
  opSrc_e                selBInt;

  assign clsD = opClass_e'(opClassD);

  hazard_track #(
    .REG_ADDR_W(REG_ADDR_W),
    .LINK_REG  (LINK_REG)
  ) u_track (
    .clk     (clk),
    .rstN    (rstN),
    .clsD    (clsD),
    .rtD     (rtD),
    .rdD     (rdD),
    .ctl     (ctl),
    .slotCls (slotCls),
    .slotDest(slotDest),
    .slotWr  (slotWr)
  );

  hazard_ctrl #(
    .REG_ADDR_W(REG_ADDR_W)
  ) u_ctrl (
    .clsD    (clsD),
    .rsD     (rsD),
    .rtD     (rtD),
    .slotCls (slotCls),
    .slotDest(slotDest),
    .slotWr  (slotWr),
    .ctl     (ctl),
    .selA    (selAInt),
    .selB    (selBInt)
  );

  assign stallD = ctl.stall;
  assign selA   = selAInt;
  assign selB   = selBInt;

endmodule

// File: rtl/hazard_checker.sv
module hazard_checker #(
  parameter int REG_ADDR_W = 5
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [3:0]            opClassD,
  input logic [REG_ADDR_W-1:0] rsD,
  input logic [REG_ADDR_W-1:0] rtD,
  input logic                  stallD,
  input logic [1:0]            selA,
  input logic [1:0]            selB
);

  // R10: a zero source never takes a forwarded value
  a_r10_zero_rs: assert property (@(posedge clk) disable iff (!rstN)
    (rsD == '0) |-> (selA == 2'd0));

  a_r10_zero_rt: assert property (@(posedge clk) disable iff (!rstN)
    (rtD == '0) |-> (selB == 2'd0));

  // R3: classes that do not read rs leave operand A on the register file
  a_r3_rs_unread: assert property (@(posedge clk) disable iff (!rstN)
    ((opClassD == 4'd0) || (opClassD == 4'd6) || (opClassD == 4'd7) || (opClassD > 4'd9))
    |-> (selA == 2'd0));

  // R4: only ALU and SW read rt
  a_r4_rt_unread: assert property (@(posedge clk) disable iff (!rstN)
    !((opClassD == 4'd1) || (opClassD == 4'd4)) |-> (selB == 2'd0));

  // R9: the inserted empty slot means a stall never repeats next cycle
  a_r9_single_stall: assert property (@(posedge clk) disable iff (!rstN)
    stallD |=> !stallD);

  // R6: stalled cycles present no forwarding select
  a_r6_stall_quiet: assert property (@(posedge clk) disable iff (!rstN)
    stallD |-> ((selA == 2'd0) && (selB == 2'd0)));

endmodule

bind pipe_hazard_unit hazard_checker #(
  .REG_ADDR_W(REG_ADDR_W)
) u_hazChk (
  .clk     (clk),
  .rstN    (rstN),
  .opClassD(opClassD),
  .rsD     (rsD),
  .rtD     (rtD),
  .stallD  (stallD),
  .selA    (selA),
  .selB    (selB)
);

// File: tb/test_pipe_hazard_unit.sv
module test_pipe_hazard_unit;

  localparam int AW = 5;
  localparam int NVEC = 28;

  // {req[3:0], class[3:0], rs, rt, rd, stall, selA[1:0], selB[1:0]}
  // class: NOP0 ALU1 ALUI2 LW3 SW4 BZ5 J6 JAL7 JR8 JALR9; sel: RF0 EX1 MEM2 WB3
  localparam logic [27:0] VEC [NVEC] = '{
    {4'd1,  4'd1, 5'd1,  5'd2,  5'd3,  1'b0, 2'd0, 2'd0},  // R1 empty pipe
    {4'd5,  4'd1, 5'd3,  5'd3,  5'd4,  1'b0, 2'd1, 2'd1},  // R5 ALU in EX
    {4'd8,  4'd2, 5'd3,  5'd5,  5'd0,  1'b0, 2'd2, 2'd0},  // R8 from MEM
    {4'd8,  4'd1, 5'd3,  5'd4,  5'd6,  1'b0, 2'd3, 2'd2},  // R8 WB and MEM
    {4'd5,  4'd1, 5'd6,  5'd5,  5'd7,  1'b0, 2'd1, 2'd2},  // R5 / R2 ALUI writes rt
    {4'd10, 4'd2, 5'd0,  5'd7,  5'd0,  1'b0, 2'd0, 2'd0},  // R10 rs zero
    {4'd7,  4'd1, 5'd7,  5'd6,  5'd8,  1'b0, 2'd1, 2'd3},  // R7 EX over MEM
    {4'd7,  4'd4, 5'd7,  5'd8,  5'd0,  1'b0, 2'd2, 2'd1},  // R7 MEM over WB
    {4'd11, 4'd5, 5'd8,  5'd0,  5'd0,  1'b0, 2'd2, 2'd0},  // R11 SW in EX skipped
    {4'd11, 4'd8, 5'd8,  5'd0,  5'd0,  1'b0, 2'd3, 2'd0},  // R11 BZ/SW skipped
    {4'd10, 4'd3, 5'd0,  5'd9,  5'd0,  1'b0, 2'd0, 2'd0},  // R10 load base r0
    {4'd6,  4'd1, 5'd9,  5'd1,  5'd10, 1'b1, 2'd0, 2'd0},  // R6 load-use
    {4'd9,  4'd1, 5'd9,  5'd1,  5'd10, 1'b0, 2'd2, 2'd0},  // R9 replay from MEM
    {4'd3,  4'd7, 5'd10, 5'd10, 5'd0,  1'b0, 2'd0, 2'd0},  // R3 JAL reads nothing
    {4'd6,  4'd1, 5'd31, 5'd10, 5'd11, 1'b1, 2'd0, 2'd0},  // R6 JAL in EX
    {4'd9,  4'd1, 5'd31, 5'd10, 5'd11, 1'b0, 2'd2, 2'd3},  // R9 / R2 link r31
    {4'd4,  4'd9, 5'd31, 5'd11, 5'd0,  1'b0, 2'd3, 2'd0},  // R4 JALR rt unread
    {4'd6,  4'd1, 5'd0,  5'd31, 5'd0,  1'b1, 2'd0, 2'd0},  // R6 JALR in EX
    {4'd9,  4'd1, 5'd0,  5'd31, 5'd0,  1'b0, 2'd0, 2'd2},  // R9 replay on B
    {4'd2,  4'd2, 5'd31, 5'd0,  5'd0,  1'b0, 2'd3, 2'd0},  // R2 JALR link in WB
    {4'd3,  4'd6, 5'd5,  5'd0,  5'd0,  1'b0, 2'd0, 2'd0},  // R3 J
    {4'd8,  4'd3, 5'd1,  5'd12, 5'd0,  1'b0, 2'd0, 2'd0},  // R8 LW issue
    {4'd6,  4'd4, 5'd2,  5'd12, 5'd0,  1'b1, 2'd0, 2'd0},  // R6 store data from load
    {4'd8,  4'd4, 5'd2,  5'd12, 5'd0,  1'b0, 2'd0, 2'd2},  // R8 load from MEM
    {4'd8,  4'd1, 5'd12, 5'd12, 5'd13, 1'b0, 2'd3, 2'd3},  // R8 load from WB
    {4'd5,  4'd1, 5'd13, 5'd13, 5'd0,  1'b0, 2'd1, 2'd1},  // R5 both operands
    {4'd2,  4'd2, 5'd13, 5'd14, 5'd0,  1'b0, 2'd2, 2'd0},  // R2 rd0 ALU not writing
    {4'd4,  4'd2, 5'd14, 5'd13, 5'd0,  1'b0, 2'd1, 2'd0}   // R4 ALUI rt unread
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [3:0]    opClassD = 4'd0;
  logic [AW-1:0] rsD = '0;
  logic [AW-1:0] rtD = '0;
  logic [AW-1:0] rdD = '0;
  logic          stallD;
  logic [1:0]    selA;
  logic [1:0]    selB;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  pipe_hazard_unit #(.REG_ADDR_W(AW), .LINK_REG(31)) i_pipe_hazard_unit (
    .clk(clk), .rstN(rstN), .opClassD(opClassD), .rsD(rsD), .rtD(rtD), .rdD(rdD),
    .stallD(stallD), .selA(selA), .selB(selB)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      miscompares++;
      $display("FAIL watchdog: run did not complete (all requirements), actual cycles=%0d expected<20000", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic drive(input logic [3:0] c, input logic [AW-1:0] s, t, d);
    @(negedge clk);
    opClassD = c; rsD = s; rtD = t; rdD = d;
    #1;
  endtask

  task automatic expect3(input string tag, input logic st, input logic [1:0] a, b);
    vectors++;
    if ({stallD, selA, selB} !== {st, a, b}) begin
      miscompares++;
      $display("FAIL %s: actual stall=%0b selA=%0d selB=%0d expected stall=%0b selA=%0d selB=%0d",
               tag, stallD, selA, selB, st, a, b);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // Vector stream; pipeline state carries from one entry to the next
    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][23:20], VEC[i][19:15], VEC[i][14:10], VEC[i][9:5]);
      vectors++;
      if ({stallD, selA, selB} !== VEC[i][4:0]) begin
        miscompares++;
        $display("FAIL R%0d vector %0d: actual stall=%0b selA=%0d selB=%0d expected stall=%0b selA=%0d selB=%0d",
                 VEC[i][27:24], i, stallD, selA, selB, VEC[i][4], VEC[i][3:2], VEC[i][1:0]);
      end
    end

    // R1: reset while writers are in flight empties every stage
    drive(4'd1, 5'd1, 5'd1, 5'd20);   // ALU writes r20
    drive(4'd3, 5'd0, 5'd21, 5'd0);   // LW writes r21
    drive(4'd1, 5'd20, 5'd21, 5'd22);
    expect3("R6 pre-reset load-use", 1'b1, 2'd0, 2'd0);
    rstN = 1'b0;
    #1;
    @(negedge clk);
    rstN = 1'b1;
    drive(4'd1, 5'd20, 5'd21, 5'd0);
    expect3("R1 after mid-run reset", 1'b0, 2'd0, 2'd0);

    // R5 / R7: same register written by EX and WB, EX supplies it
    drive(4'd2, 5'd0, 5'd23, 5'd0);   // ALUI r23 -> will be WB
    drive(4'd4, 5'd0, 5'd0, 5'd0);    // SW, writes nothing
    drive(4'd2, 5'd0, 5'd23, 5'd0);   // ALUI r23 -> EX
    drive(4'd1, 5'd23, 5'd23, 5'd0);
    expect3("R7 EX over WB", 1'b0, 2'd1, 2'd1);

    // R2: LW with rt=0 does not write, so no interlock
    drive(4'd3, 5'd1, 5'd0, 5'd0);
    drive(4'd1, 5'd0, 5'd0, 5'd24);
    expect3("R2 LW to r0 no stall", 1'b0, 2'd0, 2'd0);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule